// File: doc/BRIEF.md
# Programmable DMA Request Router

This block sits between a set of peripherals that raise DMA requests and the eight channels of a DMA controller. Each controller channel has a routing slot with a small request identifier. The identifier picks one peripheral request line, and that line drives the channel's request output. Every request line fans out to all slots, so any slot can take any line. The channel's acknowledge goes back only to the peripheral that the slot has selected. The peripheral then lowers its request once it has been served.

Software programs the slots over a simple word-addressed register bus before it enables the matching controller channel. Slot `n` sits at byte offset `4*n`. An identifier of zero leaves a slot idle. Identifier 1 is a reserved line that never asserts. Identifiers 2 to 17 select peripheral inputs 0 to 15. Any larger identifier selects nothing. The request path is purely combinational, and a register write takes effect on the next clock edge.

Top module: `dma_req_router`

## Requirements
- R1: After reset every slot holds identifier 0, all `dma_req` outputs and all `periph_ack` outputs are low, and every slot reads back as zero.
- R2: A read has `bus_en`=1 and `bus_we`=0. Slot `n` reads at byte offset `4*n`, for offsets 0x00 to 0x1C. Bits 4:0 return the stored identifier and bits 31:5 always return zero. When no read is active, `bus_rdata` is zero.
- R3: A write is accepted only when all of these hold: `bus_en`=1, `bus_we`=1, `bus_strb`=4'b1111 and the offset is valid. The slot then stores `bus_wdata[4:0]` at the next rising clock edge, and neither outputs nor read data change before that edge. A write with any byte strobe low has no effect.
- R4: A slot holding identifier 0, identifier 1 or any identifier above 17 keeps its `dma_req` low, whatever the peripheral requests are.
- R5: A slot holding identifier k, with 2 ≤ k ≤ 17, drives its `dma_req` from `periph_req[k-2]` in the same cycle, with no clock delay.
- R6: `periph_ack[p]` is the OR of `dma_ack[n]` over every slot n whose identifier is p+2. It is low when no such slot acknowledges.
- R7: A read at byte offset 0x20 or above returns zero. A write at byte offset 0x20 or above changes no slot.
- R8: Several slots may hold the same identifier. Each of them then forwards the same request, their acknowledges are ORed into that peripheral's `periph_ack`, and no error is raised.
- R9: An access whose address has bit 1 or bit 0 set is not word-aligned. Such a write changes no slot, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_strb | input | 4 | Byte strobes; a write needs all four set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| periph_req | input | 16 | Peripheral requests; bit p is identifier p+2 |
| periph_ack | output | 16 | Acknowledge returned to each peripheral |
| dma_req | output | 8 | Request to each DMA controller channel |
| dma_ack | input | 8 | Acknowledge from each DMA controller channel |

## Verification
The bench builds the router with its default parameters: eight slots, sixteen peripheral lines and a 5-bit identifier. With these values, every identifier from 0 to 31 can be written. This brings the idle value, the reserved line, both ends of the valid range and the out-of-range values within reach, next to the unmapped offsets 0x20 to 0x3F. A behavioural model tracks the slots and is compared against the requests, the acknowledges and the read data on every clock. The run mixes directed cases (shared identifiers, partial strobes, misaligned and unmapped addresses) with several thousand cycles of random traffic.

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 16,
  parameter int ID_W       = 5,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [3:0]            bus_strb,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PERIPH-1:0] periph_req,
  output logic [NUM_PERIPH-1:0] periph_ack,
  output logic [NUM_CH-1:0]     dma_req,
  input  logic [NUM_CH-1:0]     dma_ack
);
  localparam int FIRST_ID  = 2;
  localparam int LAST_ID   = FIRST_ID + NUM_PERIPH - 1;
  localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PIDX_W    = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;
  localparam int MAP_BYTES = 4 * NUM_CH;

  logic [ID_W-1:0]        sel_id  [NUM_CH];
  logic [PIDX_W-1:0]      ch_pidx [NUM_CH];
  logic [NUM_CH-1:0]      ch_hit;
  logic [NUM_CH*ID_W-1:0] cfg_flat;
  logic [IDX_W-1:0]       word_idx;
  logic                   addr_ok, wr_ok;

  assign addr_ok  = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) < MAP_BYTES);
  assign word_idx = bus_addr[IDX_W+1:2];
  assign wr_ok    = bus_en && bus_we && (bus_strb == 4'hF) && addr_ok;

  assign bus_rdata = (bus_en && !bus_we && addr_ok) ?
                     {{(32-ID_W){1'b0}}, sel_id[word_idx]} : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ID_W-1:0] off;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_id[c] <= '0;
      else if (wr_ok && (word_idx == IDX_W'(c)))
        sel_id[c] <= bus_wdata[ID_W-1:0];
    end

    assign off        = sel_id[c] - ID_W'(FIRST_ID);
    assign ch_pidx[c] = off[PIDX_W-1:0];
    assign ch_hit[c]  = (int'(sel_id[c]) >= FIRST_ID) && (int'(sel_id[c]) <= LAST_ID);
    assign dma_req[c] = ch_hit[c] && periph_req[ch_pidx[c]];
    assign cfg_flat[c*ID_W +: ID_W] = sel_id[c];

    AST_IDLE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && word_idx == IDX_W'(c) &&
       (int'(bus_wdata[ID_W-1:0]) < FIRST_ID || int'(bus_wdata[ID_W-1:0]) > LAST_ID))
      |=> !dma_req[c]); // R4
  end

  always_comb begin
    periph_ack = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int p = 0; p < NUM_PERIPH; p++)
        if (ch_hit[c] && ch_pidx[c] == PIDX_W'(p))
          periph_ack[p] = periph_ack[p] | dma_ack[c];
  end

  AST_RESERVED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:ID_W] == '0); // R2
  AST_PARTIAL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_strb != 4'hF) |=> $stable(cfg_flat)); // R3
  AST_UNMAPPED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && int'(bus_addr) >= MAP_BYTES) |=> $stable(cfg_flat)); // R7
  AST_MISALIGNED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[1:0] != 2'b00) |=> $stable(cfg_flat)); // R9
  AST_NO_ACK_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack == '0) |-> (periph_ack == '0)); // R6
  AST_ACK_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(periph_ack) <= $countones(dma_ack)); // R6
endmodule

// File: tb/test_dma_req_router.sv
`timescale 1ns/1ps
module test_dma_req_router;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_strb = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] periph_req = '0, periph_ack;
  logic [7:0]  dma_req, dma_ack = '0;

  int checks = 0, fails = 0, cycles = 0;
  int model_id [8];
  bit compare_on = 1'b0;

  always #2 clk = ~clk;

  dma_req_router i_dma_req_router (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .periph_req(periph_req), .periph_ack(periph_ack),
    .dma_req(dma_req), .dma_ack(dma_ack));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit acc_valid(input logic [7:0] a);
    return a[1:0] == 2'b00 && a < 8'h20;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) model_id[c] = 0;
    end else if (bus_en && bus_we && bus_strb == 4'hF && acc_valid(bus_addr)) begin
      model_id[bus_addr >> 2] = int'(bus_wdata[4:0]);
    end
  end

  always @(negedge clk) begin
    #1;
    if (compare_on) begin
      logic [7:0] er;
      logic [15:0] ea;
      logic [31:0] ed;
      er = '0; ea = '0; ed = '0;
      for (int c = 0; c < 8; c++)
        if (model_id[c] >= 2 && model_id[c] <= 17) begin
          er[c] = periph_req[model_id[c] - 2];
          if (dma_ack[c]) ea[model_id[c] - 2] = 1'b1;
        end
      if (bus_en && !bus_we && acc_valid(bus_addr)) ed = 32'(model_id[bus_addr >> 2]);
      chk(dma_req === er, "R5 R4 request routing", 32'(dma_req), 32'(er));
      chk(periph_ack === ea, "R6 R8 ack return", 32'(periph_ack), 32'(ea));
      chk(bus_rdata === ed, "R2 R7 R9 read data", bus_rdata, ed);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_strb = s;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait (cycles >= 150000);
    chk(1'b0, "watchdog expired", 32'(cycles), 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_on = 1;
    // R1: reset state
    for (int c = 0; c < 8; c++) begin
      rd(8'(4*c), d);
      chk(d == 0, "R1 slot reset value", d, 0);
    end
    chk(dma_req == 0 && periph_ack == 0, "R1 outputs low", 32'({dma_req, periph_ack}), 0);

    wr(8'h00, 32'd2);
    wr(8'h04, 32'd17);
    wr(8'h08, 32'd1);
    wr(8'h0C, 32'd0);
    wr(8'h10, 32'd31);
    wr(8'h14, 32'd10);
    wr(8'h18, 32'd10);
    wr(8'h1C, 32'hFFFF_FFE5);
    rd(8'h1C, d);
    chk(d == 32'd5, "R2 reserved bits read zero", d, 5);

    // R4 / R5: all requests high
    @(negedge clk); periph_req = 16'hFFFF;
    #1 chk(dma_req[4:2] == 3'b000, "R4 idle/reserved/out-of-range low", 32'(dma_req[4:2]), 0);
    chk(dma_req[1] && dma_req[0], "R5 edge ids forward", 32'(dma_req), 32'h3);
    @(negedge clk); periph_req = 16'h8000;
    #1 chk(dma_req == 8'h02, "R5 id 17 only", 32'(dma_req), 32'h02);

    // R8: shared id 10 on slots 5 and 6
    @(negedge clk); periph_req = 16'h0100; dma_ack = 8'h40;
    #1 chk(dma_req == 8'h60, "R8 shared request", 32'(dma_req), 32'h60);
    chk(periph_ack == 16'h0100, "R8 R6 shared ack", 32'(periph_ack), 32'h100);
    @(negedge clk); dma_ack = 8'h1C; periph_req = 16'hFFFF;
    #1 chk(periph_ack == 16'h0000, "R6 unselected acks dropped", 32'(periph_ack), 0);
    @(negedge clk); dma_ack = 0; periph_req = 0;

    // R3: partial strobes ignored; write visible only after the edge
    wr(8'h00, 32'd9, 4'h7);
    rd(8'h00, d);
    chk(d == 2, "R3 partial write ignored", d, 2);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'd3; bus_strb = 4'hF; periph_req = 16'h0002;
    #1 chk(dma_req[0] == 1'b0, "R3 no change before edge", 32'(dma_req[0]), 0);
    @(negedge clk); bus_en = 0; bus_we = 0;
    #1 chk(dma_req[0] == 1'b1, "R3 change after edge", 32'(dma_req[0]), 1);

    // R9 / R7: misaligned and unmapped
    wr(8'h01, 32'd4);
    wr(8'h06, 32'd4);
    wr(8'h20, 32'd4);
    wr(8'h3C, 32'd4);
    rd(8'h00, d); chk(d == 3, "R9 misaligned write ignored", d, 3);
    rd(8'h04, d); chk(d == 17, "R9 misaligned write ignored", d, 17);
    rd(8'h05, d); chk(d == 0, "R9 misaligned read zero", d, 0);
    rd(8'h20, d); chk(d == 0, "R7 unmapped read zero", d, 0);
    rd(8'h1C, d); chk(d == 5, "R7 unmapped write no effect", d, 5);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      periph_req = 16'($urandom);
      dma_ack    = 8'($urandom);
      bus_en     = ($urandom_range(0, 3) != 0);
      bus_we     = ($urandom_range(0, 3) == 0);
      bus_addr   = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 63)) : 8'($urandom_range(0, 7) * 4);
      bus_strb   = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'hF;
      bus_wdata  = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 18));
    end
    @(negedge clk); bus_en = 0; bus_we = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule